// File: doc/BRIEF.md
# Two-Level Addressed Control Message Network

This block joins a set of processor clusters through many small hardware queues. The queues carry short control and synchronization words between the clusters. Each cluster owns a group of physical queues. Every core command names a destination as a pair: a cluster number, then a logical queue number inside that cluster. A connection table, one entry per (cluster, logical queue), translates the logical number into one of that cluster's physical queues. The whole table can be rewritten at run time, so any logical channel can be steered to any queue in its group.

Each cluster has one command port and issues one command per cycle. A send pushes a word toward (cluster, queue). A receive pops a word from one of the cluster's own queues. The command completes in the cycle it is presented, or it is refused in that same cycle with a block flag. The calling thread then sleeps and retries, with no software handling involved. Refused commands never lose a word and never duplicate one. Several clusters may send to one queue in the same cycle; a round-robin arbiter for each queue picks one of them.

Every physical queue runs a small state machine with three states: EMPTY, HOLDING and FULL. Its transitions are:
- EMPTY to HOLDING on a push.
- HOLDING to FULL on a push without a pop that fills the last slot.
- HOLDING to EMPTY on a pop without a push that takes the last word.
- FULL to HOLDING on a pop.
- A push and a pop together in HOLDING leave the state as it is.

Top module: `ctlnet_top`

## Requirements
- R1: After reset every queue is EMPTY (all fifo_empty bits 1, all fifo_full bits 0), no command reports done, and the connection table maps logical queue f of every cluster to physical queue f.
- R2: A completed send from any cluster to (cid, fid) enters physical queue table[cid][fid] of cluster cid. A completed receive by cluster c with fid pops physical queue table[c][fid] of cluster c. Words leave each queue in the order they entered.
- R3: A command completes in the cycle it is presented (cmd_done high in that cycle), and a completed receive shows its word on cmd_rdata in that same cycle. A valid command that does not complete raises cmd_block in that cycle.
- R4: A send to a queue holding DEPTH (4) words is blocked and writes nothing. The word is neither dropped nor duplicated when it is later retried.
- R5: A receive from an empty queue is blocked and changes no state.
- R6: When several clusters send to the same physical queue in one cycle, only one is accepted. The search starts at the cluster after the one last accepted by that queue, wrapping around, and cluster 0 is searched first after reset.
- R7: A connection-table write (cfg_valid) takes effect, with cfg_done high, only if the physical queue the entry currently selects is empty and receives no push in that cycle. Otherwise cfg_done is low and the table keeps its old value.
- R8: fifo_full and fifo_empty report each physical queue at bit index cid*N_FIFOS + physical queue number. fifo_full means DEPTH words are held and fifo_empty means none are held.
- R9: A receive ignores cmd_cid and always reads from the issuing cluster's own queues.
- R10: A send and a receive on the same non-empty, non-full queue in one cycle both complete. The receive returns the older head word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | N_CLUSTERS | Command present, one bit per cluster |
| cmd_recv | input | N_CLUSTERS | 1 = receive, 0 = send |
| cmd_cid | input | N_CLUSTERS*log2(N_CLUSTERS) | Destination cluster of a send |
| cmd_fid | input | N_CLUSTERS*log2(N_FIFOS) | Logical queue number |
| cmd_wdata | input | N_CLUSTERS*DWIDTH | Word to send |
| cmd_done | output | N_CLUSTERS | Command completed this cycle |
| cmd_block | output | N_CLUSTERS | Command refused this cycle |
| cmd_rdata | output | N_CLUSTERS*DWIDTH | Word returned by a completed receive |
| fifo_full | output | N_CLUSTERS*N_FIFOS | Per-queue full flag |
| fifo_empty | output | N_CLUSTERS*N_FIFOS | Per-queue empty flag |
| cfg_valid | input | 1 | Connection-table write request |
| cfg_cid | input | log2(N_CLUSTERS) | Cluster of the entry |
| cfg_lfid | input | log2(N_FIFOS) | Logical queue of the entry |
| cfg_pfid | input | log2(N_FIFOS) | New physical queue |
| cfg_done | output | 1 | Table write applied this cycle |

## Verification
The assertions watch every cycle for these rules:
- No queue is pushed while FULL and none is popped while EMPTY.
- The queue state agrees with its word count.
- Each arbiter grants at most one cluster and never grants the same cluster twice in a row while others are waiting.
- A table change leaves the old queue empty on the next cycle.

Only the scenarios can show the end-to-end results:
- Words arrive in order at the queue the table selects.
- The rotating grant order under contention.
- The rejection and later success of table writes.
- Blocked commands never lose or repeat a word.

// File: rtl/ctlnet_pkg.sv
package ctlnet_pkg;

    typedef enum logic [1:0] {
        FS_EMPTY = 2'd0,
        FS_HOLD  = 2'd1,
        FS_FULL  = 2'd2
    } fifo_state_e;

endpackage

// File: rtl/ctlnet_fifo.sv
module ctlnet_fifo
    import ctlnet_pkg::*;
#(
    parameter int DEPTH  = 4,
    parameter int DWIDTH = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic              pop,
    input  logic [DWIDTH-1:0] wdata,
    output logic [DWIDTH-1:0] head,
    output logic              full,
    output logic              empty
);

    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    fifo_state_e       st, st_nx;
    logic [CW-1:0]     count;
    logic [PW-1:0]     wp, rp;
    logic [DWIDTH-1:0] mem [DEPTH];

    function automatic logic [PW-1:0] bump(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) st <= FS_EMPTY;
        else        st <= st_nx;
    end

    // next state
    always_comb begin
        st_nx = st;
        unique case (st)
            FS_EMPTY: if (push) st_nx = (DEPTH == 1) ? FS_FULL : FS_HOLD;
            FS_HOLD: begin
                if (push && !pop && count == CW'(DEPTH - 1)) st_nx = FS_FULL;
                else if (pop && !push && count == CW'(1))   st_nx = FS_EMPTY;
            end
            FS_FULL:  if (pop) st_nx = (DEPTH == 1) ? FS_EMPTY : FS_HOLD;
            default:  st_nx = FS_EMPTY;
        endcase
    end

    // outputs
    always_comb begin
        full  = (st == FS_FULL);
        empty = (st == FS_EMPTY);
        head  = mem[rp];
    end

    // storage and pointers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (push) begin
                mem[wp] <= wdata;
                wp      <= bump(wp);
            end
            if (pop) rp <= bump(rp);
            if (push && !pop)      count <= count + 1'b1;
            else if (pop && !push) count <= count - 1'b1;
        end
    end

    assert_no_overflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
        full |-> !push);
    assert_no_underflow_R5: assert property (@(posedge clk) disable iff (!rst_n)
        empty |-> !pop);
    assert_state_count_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (empty == (count == '0)) && (full == (count == CW'(DEPTH))));

endmodule

// File: rtl/ctlnet_rr.sv
module ctlnet_rr #(
    parameter int N = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] req,
    input  logic         advance,
    output logic [N-1:0] grant
);

    localparam int IW = (N > 1) ? $clog2(N) : 1;

    logic [IW-1:0] last, win;

    always_comb begin
        int idx;
        grant = '0;
        win   = last;
        for (int off = 1; off <= N; off++) begin
            idx = (int'(last) + off) % N;
            if (req[idx] && grant == '0) begin
                grant[idx] = 1'b1;
                win        = IW'(idx);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)                  last <= IW'(N - 1);
        else if (advance && |grant)  last <= win;
    end

    assert_one_grant_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && ((grant & ~req) == '0));
    assert_rotates_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && |grant) |=> (($countones(req) < 2) || ((grant & $past(grant)) == '0)));

endmodule

// File: rtl/ctlnet_map.sv
module ctlnet_map #(
    parameter int NCL = 4,
    parameter int NFF = 8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_valid,
    input  logic [$clog2(NCL)-1:0]      cfg_cid,
    input  logic [$clog2(NFF)-1:0]      cfg_lfid,
    input  logic [$clog2(NFF)-1:0]      cfg_pfid,
    input  logic                        cfg_allow,
    output logic [$clog2(NFF)-1:0]      cfg_old,
    output logic [NCL*NFF*$clog2(NFF)-1:0] tbl_flat,
    output logic                        cfg_done
);

    localparam int FIDW = $clog2(NFF);
    localparam int NENT = NCL * NFF;

    logic [FIDW-1:0] tbl [NENT];
    int              sel;

    always_comb begin
        sel      = int'(cfg_cid) * NFF + int'(cfg_lfid);
        cfg_old  = tbl[sel];
        cfg_done = cfg_valid && cfg_allow;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NENT; i++) tbl[i] <= FIDW'(i % NFF);
        end else if (cfg_done) begin
            tbl[sel] <= cfg_pfid;
        end
    end

    for (genvar e = 0; e < NENT; e++) begin : g_flat
        assign tbl_flat[e*FIDW +: FIDW] = tbl[e];
    end

    assert_table_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_done |=> $stable(tbl_flat));

endmodule

// File: rtl/ctlnet_top.sv
module ctlnet_top #(
    parameter int N_CLUSTERS = 4,
    parameter int N_FIFOS    = 8,
    parameter int DEPTH      = 4,
    parameter int DWIDTH     = 32
) (
    input  logic                                   clk,
    input  logic                                   rst_n,
    input  logic [N_CLUSTERS-1:0]                  cmd_valid,
    input  logic [N_CLUSTERS-1:0]                  cmd_recv,
    input  logic [N_CLUSTERS*$clog2(N_CLUSTERS)-1:0] cmd_cid,
    input  logic [N_CLUSTERS*$clog2(N_FIFOS)-1:0]  cmd_fid,
    input  logic [N_CLUSTERS*DWIDTH-1:0]           cmd_wdata,
    output logic [N_CLUSTERS-1:0]                  cmd_done,
    output logic [N_CLUSTERS-1:0]                  cmd_block,
    output logic [N_CLUSTERS*DWIDTH-1:0]           cmd_rdata,
    output logic [N_CLUSTERS*N_FIFOS-1:0]          fifo_full,
    output logic [N_CLUSTERS*N_FIFOS-1:0]          fifo_empty,
    input  logic                                   cfg_valid,
    input  logic [$clog2(N_CLUSTERS)-1:0]          cfg_cid,
    input  logic [$clog2(N_FIFOS)-1:0]             cfg_lfid,
    input  logic [$clog2(N_FIFOS)-1:0]             cfg_pfid,
    output logic                                   cfg_done
);

    localparam int CIDW = $clog2(N_CLUSTERS);
    localparam int FIDW = $clog2(N_FIFOS);
    localparam int NTOT = N_CLUSTERS * N_FIFOS;
    localparam int GW   = $clog2(NTOT);

    logic [NTOT*FIDW-1:0]                tbl_flat;
    logic [N_CLUSTERS-1:0][GW-1:0]       snd_g, rcv_g;
    logic [NTOT-1:0][N_CLUSTERS-1:0]     gnt;
    logic [NTOT-1:0][DWIDTH-1:0]         head;
    logic [NTOT-1:0]                     push, pop, full_w, empty_w;
    logic [FIDW-1:0]                     cfg_old;
    logic [GW-1:0]                       old_g;
    logic                                cfg_allow;

    // address translation: (cluster, logical queue) -> global physical queue
    always_comb begin
        int c, f;
        for (int k = 0; k < N_CLUSTERS; k++) begin
            c = int'(cmd_cid[k*CIDW +: CIDW]);
            f = int'(cmd_fid[k*FIDW +: FIDW]);
            snd_g[k] = GW'(c * N_FIFOS + int'(tbl_flat[(c*N_FIFOS + f)*FIDW +: FIDW]));
            rcv_g[k] = GW'(k * N_FIFOS + int'(tbl_flat[(k*N_FIFOS + f)*FIDW +: FIDW]));
        end
    end

    for (genvar g = 0; g < NTOT; g++) begin : g_q
        localparam int OWNER = g / N_FIFOS;
        logic [N_CLUSTERS-1:0] req;
        logic [DWIDTH-1:0]     wsel;

        always_comb begin
            wsel = '0;
            for (int k = 0; k < N_CLUSTERS; k++) begin
                req[k] = cmd_valid[k] && !cmd_recv[k] && (snd_g[k] == GW'(g));
                if (gnt[g][k]) wsel = wsel | cmd_wdata[k*DWIDTH +: DWIDTH];
            end
        end

        assign push[g] = (|gnt[g]) && !full_w[g];
        assign pop[g]  = cmd_valid[OWNER] && cmd_recv[OWNER] &&
                         (rcv_g[OWNER] == GW'(g)) && !empty_w[g];

        ctlnet_rr #(.N(N_CLUSTERS)) u_arb (
            .clk     (clk),
            .rst_n   (rst_n),
            .req     (req),
            .advance (push[g]),
            .grant   (gnt[g])
        );

        ctlnet_fifo #(.DEPTH(DEPTH), .DWIDTH(DWIDTH)) u_fifo (
            .clk   (clk),
            .rst_n (rst_n),
            .push  (push[g]),
            .pop   (pop[g]),
            .wdata (wsel),
            .head  (head[g]),
            .full  (full_w[g]),
            .empty (empty_w[g])
        );
    end

    // command responses
    always_comb begin
        cmd_done  = '0;
        cmd_rdata = '0;
        for (int k = 0; k < N_CLUSTERS; k++) begin
            if (cmd_valid[k]) begin
                if (cmd_recv[k]) begin
                    cmd_done[k] = !empty_w[rcv_g[k]];
                    if (!empty_w[rcv_g[k]])
                        cmd_rdata[k*DWIDTH +: DWIDTH] = head[rcv_g[k]];
                end else begin
                    cmd_done[k] = gnt[snd_g[k]][k] && !full_w[snd_g[k]];
                end
            end
        end
        cmd_block = cmd_valid & ~cmd_done;
    end

    assign old_g      = GW'(int'(cfg_cid) * N_FIFOS + int'(cfg_old));
    assign cfg_allow  = empty_w[old_g] && !push[old_g];
    assign fifo_full  = full_w;
    assign fifo_empty = empty_w;

    ctlnet_map #(.NCL(N_CLUSTERS), .NFF(N_FIFOS)) u_map (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_valid (cfg_valid),
        .cfg_cid   (cfg_cid),
        .cfg_lfid  (cfg_lfid),
        .cfg_pfid  (cfg_pfid),
        .cfg_allow (cfg_allow),
        .cfg_old   (cfg_old),
        .tbl_flat  (tbl_flat),
        .cfg_done  (cfg_done)
    );

    for (genvar k = 0; k < N_CLUSTERS; k++) begin : g_chk
        assert_send_full_blocks_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[k] && !cmd_recv[k] && full_w[snd_g[k]]) |-> !cmd_done[k]);
        assert_recv_empty_blocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (cmd_valid[k] && cmd_recv[k] && empty_w[rcv_g[k]]) |-> cmd_block[k]);
    end

    assert_cfg_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_done |=> empty_w[$past(old_g)]);

endmodule

// File: tb/ctlnet_top_tb.sv
module ctlnet_top_tb;

    localparam int NCL = 4, NFF = 8, DW = 32, NT = NCL * NFF;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [NCL-1:0]  cmd_valid, cmd_recv, cmd_done, cmd_block;
    logic [NCL*2-1:0]  cmd_cid;
    logic [NCL*3-1:0]  cmd_fid;
    logic [NCL*DW-1:0] cmd_wdata, cmd_rdata;
    logic [NT-1:0]   fifo_full, fifo_empty;
    logic            cfg_valid, cfg_done;
    logic [1:0]      cfg_cid;
    logic [2:0]      cfg_lfid, cfg_pfid;

    int checks = 0, errors = 0;
    int bmap [NT];
    logic [31:0] sb [NT][$];

    always #10 clk = ~clk;

    ctlnet_top u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_recv(cmd_recv),
        .cmd_cid(cmd_cid), .cmd_fid(cmd_fid), .cmd_wdata(cmd_wdata),
        .cmd_done(cmd_done), .cmd_block(cmd_block), .cmd_rdata(cmd_rdata),
        .fifo_full(fifo_full), .fifo_empty(fifo_empty), .cfg_valid(cfg_valid),
        .cfg_cid(cfg_cid), .cfg_lfid(cfg_lfid), .cfg_pfid(cfg_pfid), .cfg_done(cfg_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        cmd_valid = '0; cmd_recv = '0; cmd_cid = '0; cmd_fid = '0; cmd_wdata = '0;
        cfg_valid = 1'b0; cfg_cid = '0; cfg_lfid = '0; cfg_pfid = '0;
    endtask

    task automatic set_cmd(input int k, input logic rcv, input int cid, input int fid,
                           input logic [31:0] d);
        cmd_valid[k] = 1'b1;
        cmd_recv[k]  = rcv;
        cmd_cid[k*2 +: 2]   = 2'(cid);
        cmd_fid[k*3 +: 3]   = 3'(fid);
        cmd_wdata[k*DW +: DW] = d;
    endtask

    task automatic set_cfg(input int c, input int l, input int p);
        cfg_valid = 1'b1; cfg_cid = 2'(c); cfg_lfid = 3'(l); cfg_pfid = 3'(p);
    endtask

    // driver pushes expected words; monitor side pops and compares on receive
    task automatic step(input logic [NCL-1:0] exp_done, input logic exp_cfg, input string req);
        int g;
        logic [31:0] e;
        #1;
        chk(cmd_done === exp_done, req, "cmd_done", 64'(cmd_done), 64'(exp_done));
        chk(cmd_block === (cmd_valid & ~exp_done), "R3", "cmd_block",
            64'(cmd_block), 64'(cmd_valid & ~exp_done));
        chk(cfg_done === exp_cfg, "R7", "cfg_done", 64'(cfg_done), 64'(exp_cfg));
        for (int k = 0; k < NCL; k++) begin
            if (cmd_done[k]) begin
                if (cmd_recv[k]) begin
                    g = k * NFF + bmap[k * NFF + int'(cmd_fid[k*3 +: 3])];
                    if (sb[g].size() == 0) begin
                        chk(1'b0, "R2", "unexpected word", 64'(cmd_rdata[k*DW +: DW]), 64'd0);
                    end else begin
                        e = sb[g].pop_front();
                        chk(cmd_rdata[k*DW +: DW] === e, "R2", "rdata order",
                            64'(cmd_rdata[k*DW +: DW]), 64'(e));
                    end
                end else begin
                    g = int'(cmd_cid[k*2 +: 2]) * NFF +
                        bmap[int'(cmd_cid[k*2 +: 2]) * NFF + int'(cmd_fid[k*3 +: 3])];
                    sb[g].push_back(cmd_wdata[k*DW +: DW]);
                end
            end
        end
        if (cfg_done) bmap[int'(cfg_cid) * NFF + int'(cfg_lfid)] = int'(cfg_pfid);
        @(posedge clk);
        @(negedge clk);
        idle();
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < NT; i++) bmap[i] = i % NFF;
        idle();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1 reset state
        chk(fifo_empty === '1, "R1", "fifo_empty", 64'(fifo_empty), 64'hFFFFFFFF);
        chk(fifo_full === '0, "R1", "fifo_full", 64'(fifo_full), 64'd0);
        chk(cmd_done === '0, "R1", "cmd_done", 64'(cmd_done), 64'd0);
        @(negedge clk);

        // R5 receive from empty queue blocks
        set_cmd(0, 1'b1, 0, 0, 0);
        step(4'b0000, 1'b0, "R5");
        chk(fifo_empty[0] === 1'b1, "R5", "queue untouched", 64'(fifo_empty[0]), 64'd1);

        // R2/R8 fill queue (2,3) from cluster 1
        for (int i = 0; i < 4; i++) begin
            set_cmd(1, 1'b0, 2, 3, 32'h11 + 32'(i));
            step(4'b0010, 1'b0, "R2");
        end
        chk(fifo_full[19] === 1'b1, "R8", "full bit 19", 64'(fifo_full[19]), 64'd1);
        chk(fifo_empty[19] === 1'b0, "R8", "empty bit 19", 64'(fifo_empty[19]), 64'd0);

        // R4 send to a full queue blocks
        set_cmd(1, 1'b0, 2, 3, 32'hBAD);
        step(4'b0000, 1'b0, "R4");

        // R9 receive ignores cmd_cid; R3 same-cycle data
        for (int i = 0; i < 4; i++) begin
            set_cmd(2, 1'b1, 3, 3, 0);
            step(4'b0100, 1'b0, "R9");
        end
        set_cmd(2, 1'b1, 1, 3, 0);
        step(4'b0000, 1'b0, "R4");
        chk(fifo_empty[19] === 1'b1, "R4", "no extra word", 64'(fifo_empty[19]), 64'd1);

        // R6 round robin on queue (1,5)
        set_cmd(0, 1'b0, 1, 5, 32'hA0); set_cmd(1, 1'b0, 1, 5, 32'hB0); set_cmd(3, 1'b0, 1, 5, 32'hD0);
        step(4'b0001, 1'b0, "R6");
        set_cmd(0, 1'b0, 1, 5, 32'hA1); set_cmd(1, 1'b0, 1, 5, 32'hB0); set_cmd(3, 1'b0, 1, 5, 32'hD0);
        step(4'b0010, 1'b0, "R6");
        set_cmd(0, 1'b0, 1, 5, 32'hA1); set_cmd(3, 1'b0, 1, 5, 32'hD0);
        step(4'b1000, 1'b0, "R6");
        set_cmd(0, 1'b0, 1, 5, 32'hA1);
        step(4'b0001, 1'b0, "R6");
        set_cmd(1, 1'b0, 1, 5, 32'hB1); set_cmd(2, 1'b0, 1, 5, 32'hC1);
        step(4'b0000, 1'b0, "R4");
        for (int i = 0; i < 4; i++) begin
            set_cmd(1, 1'b1, 0, 5, 0);
            step(4'b0010, 1'b0, "R6");
        end

        // R10 push and pop together
        set_cmd(3, 1'b0, 2, 0, 32'hE0);
        step(4'b1000, 1'b0, "R10");
        set_cmd(3, 1'b0, 2, 0, 32'hE1); set_cmd(2, 1'b1, 0, 0, 0);
        step(4'b1100, 1'b0, "R10");
        set_cmd(2, 1'b1, 0, 0, 0);
        step(4'b0100, 1'b0, "R10");
        chk(fifo_empty[16] === 1'b1, "R10", "drained", 64'(fifo_empty[16]), 64'd1);

        // R7 connection table
        set_cfg(0, 2, 6);
        step(4'b0000, 1'b1, "R7");
        set_cmd(1, 1'b0, 0, 2, 32'hC0);
        step(4'b0010, 1'b0, "R7");
        chk(fifo_empty[6] === 1'b0, "R7", "remapped queue 6", 64'(fifo_empty[6]), 64'd0);
        chk(fifo_empty[2] === 1'b1, "R7", "old queue 2", 64'(fifo_empty[2]), 64'd1);
        set_cfg(0, 2, 1);
        step(4'b0000, 1'b0, "R7");
        set_cmd(1, 1'b0, 0, 2, 32'hC1);
        step(4'b0010, 1'b0, "R7");
        chk(fifo_empty[1] === 1'b1, "R7", "table unchanged", 64'(fifo_empty[1]), 64'd1);
        set_cmd(0, 1'b1, 0, 2, 0);
        step(4'b0001, 1'b0, "R7");
        set_cmd(0, 1'b1, 0, 2, 0);
        step(4'b0001, 1'b0, "R7");
        set_cfg(0, 2, 1); set_cmd(1, 1'b0, 0, 2, 32'hC2);
        step(4'b0010, 1'b0, "R7");
        set_cmd(0, 1'b1, 0, 2, 0);
        step(4'b0001, 1'b0, "R7");
        set_cfg(0, 2, 1);
        step(4'b0000, 1'b1, "R7");
        set_cmd(1, 1'b0, 0, 2, 32'hC3);
        step(4'b0010, 1'b0, "R7");
        chk(fifo_empty[1] === 1'b0, "R7", "new target queue 1", 64'(fifo_empty[1]), 64'd0);
        chk(fifo_empty[6] === 1'b1, "R7", "queue 6 idle", 64'(fifo_empty[6]), 64'd1);
        set_cmd(0, 1'b1, 0, 2, 0);
        step(4'b0001, 1'b0, "R7");

        for (int g = 0; g < NT; g++)
            chk(sb[g].size() == 0, "R2", "leftover words", 64'(sb[g].size()), 64'd0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule